// File: doc/BRIEF.md
# Accumulator Stored-Program Processor

This block is a small multi-cycle processor core with one accumulator register. Program and data live together in one word-addressed memory outside the block. The core reaches that memory only through its own address-holding register and data-holding register. It keeps repeating a fetch, decode and execute loop until it reaches a stop instruction or an undefined opcode.

The instruction set covers data transfer, single-operand addition, an unsigned compare that records a three-way result, and unconditional and conditional jumps. Two-operand instructions take their second address from the memory word that follows them. The memory port is a synchronous single-port RAM interface with a fixed read latency of one cycle. It has no valid/ready handshake and no back-pressure: the core puts an address out, waits one cycle, and then captures the returned word. The `halted` and `pc` outputs are plain status pins.

Top module: `acc_cpu`

## Requirements
- R1: While reset is held and in the first cycle after it, `pc` is 0, `halted` is 0 and `mem_we` is 0. The accumulator and all three compare flags are cleared, so right after reset a greater-or-equal or less-or-equal jump is not taken and a not-equal jump is taken.
- R2: An instruction word carries the opcode in bits [15:12] and an address X in bits [11:0]. Each instruction starts with four fetch cycles: address to MAR, a wait cycle, data into MDR, then MDR into IR and PC+1. `pc` shows the incremented value from the fifth cycle of the instruction.
- R3: LOAD (opcode 0) copies cell X into the accumulator and takes 8 cycles. STORE (opcode 1) takes 6 cycles, and in its sixth cycle `mem_we` is 1 with `mem_addr`=X and `mem_wdata` equal to the accumulator. This is the only write cycle of a STORE.
- R4: ADD (opcode 3) replaces the accumulator with the sum of the accumulator and cell X, modulo 2^16, in 8 cycles.
- R5: MOVE (opcode 2) reads its destination Y from bits [11:0] of the next word and copies cell X into cell Y. It takes 12 cycles, writes only in the twelfth, and advances the PC by 2.
- R6: COMPARE (opcode 4) reads Y from the next word and compares cell X with cell Y as unsigned numbers. It sets exactly one of GT, EQ and LT, takes 14 cycles, and advances the PC by 2. The flags change only when a COMPARE completes.
- R7: JUMP (opcode 5) loads the PC with X and takes 5 cycles.
- R8: These opcodes load the PC with X when their condition holds, and otherwise go on at PC+1, in 5 cycles: 6 (GT), 7 (GT or EQ), 8 (LT), 9 (LT or EQ), 10 (EQ), 11 (not EQ).
- R9: HALT (opcode 15) raises `halted` from its sixth cycle onward. After that `pc` holds the HALT address plus one and no memory write ever occurs.
- R10: The undefined opcodes 12, 13 and 14 stop the core in the same way as HALT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 12 | Memory address, driven from the address register |
| mem_wdata | output | 16 | Write data, driven from the data register |
| mem_we | output | 1 | Write enable for one cycle |
| mem_rdata | input | 16 | Read data, valid one cycle after the address was sampled |
| halted | output | 1 | Core has stopped |
| pc | output | 12 | Program counter |

## Verification
The results come due at fixed offsets from the first fetch cycle of each instruction. The PC increment is visible in cycle 5, a second increment for two-word instructions in cycle 9, and a taken jump's target in cycle 6, where the next instruction begins. The STORE write lands in cycle 6 and the MOVE write in cycle 12, and `halted` rises in cycle 6 of a stopping opcode. The bench's reference model executes each instruction whole at its first cycle and then replays this timetable cycle by cycle. It samples `pc`, `halted` and the write port at every falling edge, so each expected value is compared in exactly the cycle it is due. Accumulator and flag results are observed through later STOREs and conditional jumps.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OPW = 4;

  // opcode values are architectural: programs depend on them
  typedef enum logic [OPW-1:0] {
    OP_LOAD  = 4'd0,
    OP_STORE = 4'd1,
    OP_MOVE  = 4'd2,
    OP_ADD   = 4'd3,
    OP_CMP   = 4'd4,
    OP_JMP   = 4'd5,
    OP_JGT   = 4'd6,
    OP_JGE   = 4'd7,
    OP_JLT   = 4'd8,
    OP_JLE   = 4'd9,
    OP_JEQ   = 4'd10,
    OP_JNE   = 4'd11,
    OP_HALT  = 4'd15
  } opcode_e;

  typedef enum logic [2:0] {
    K_LOAD, K_STORE, K_MOVE, K_ADD, K_CMP, K_JUMP, K_STOP
  } kind_e;

  typedef enum logic {
    SEL_PASS,
    SEL_ADD
  } alu_sel_e;

  typedef struct packed {
    logic lt;
    logic eq;
    logic gt;
  } flags_t;

  typedef enum logic [3:0] {
    S_F0,    // PC -> MAR
    S_F1,    // memory read wait
    S_F2,    // read data -> MDR
    S_F3,    // MDR -> IR, PC + 1
    S_DEC,   // opcode decode
    S_X1,    // second word: wait
    S_X2,    // second word -> MDR
    S_X3,    // keep second address, PC + 1
    S_R1,    // operand read wait
    S_R2,    // operand -> MDR
    S_EX,    // execute
    S_WR,    // memory write
    S_HALT
  } state_e;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_cpu_pkg::*;
(
  input  logic [OPW-1:0] opcode,
  output kind_e          kind,
  output alu_sel_e       sel
);

  always_comb begin
    kind = K_STOP;
    sel  = SEL_PASS;
    case (opcode)
      OP_LOAD:  kind = K_LOAD;
      OP_STORE: kind = K_STORE;
      OP_MOVE:  kind = K_MOVE;
      OP_ADD: begin
        kind = K_ADD;
        sel  = SEL_ADD;
      end
      OP_CMP:   kind = K_CMP;
      OP_JMP, OP_JGT, OP_JGE, OP_JLT,
      OP_JLE, OP_JEQ, OP_JNE: kind = K_JUMP;
      default:  kind = K_STOP;   // HALT and every undefined code
    endcase
  end

endmodule

// File: rtl/acc_branch.sv
module acc_branch
  import acc_cpu_pkg::*;
(
  input  logic [OPW-1:0] opcode,
  input  flags_t         flags,
  output logic           take
);

  always_comb begin
    case (opcode)
      OP_JMP:  take = 1'b1;
      OP_JGT:  take = flags.gt;
      OP_JGE:  take = flags.gt | flags.eq;
      OP_JLT:  take = flags.lt;
      OP_JLE:  take = flags.lt | flags.eq;
      OP_JEQ:  take = flags.eq;
      OP_JNE:  take = ~flags.eq;
      default: take = 1'b0;
    endcase
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_cpu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] operand,
  input  logic [DW-1:0] left,
  input  alu_sel_e      sel,
  output logic [DW-1:0] result,
  output flags_t        relation
);

  logic [DW-1:0] sum;

  assign sum = acc + operand;

  // result multiplexer steered by the decoded select
  always_comb begin
    case (sel)
      SEL_ADD: result = sum;
      default: result = operand;
    endcase
  end

  // unsigned three-way relation of left against operand
  assign relation.gt = (left >  operand);
  assign relation.eq = (left == operand);
  assign relation.lt = (left <  operand);

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  output logic          halted,
  output logic [AW-1:0] pc
);

  localparam int OPLSB = DW - OPW;

  state_e        state_q;
  logic [AW-1:0] pc_q;
  logic [AW-1:0] mar_q;
  logic [DW-1:0] mdr_q;
  logic [DW-1:0] ir_q;
  logic [DW-1:0] acc_q;
  logic [DW-1:0] left_q;
  logic [AW-1:0] yaddr_q;
  logic          second_q;
  flags_t        flag_q;

  logic [OPW-1:0] ir_op;
  logic [AW-1:0]  ir_addr;
  kind_e          kind;
  alu_sel_e       sel;
  logic           take;
  logic [DW-1:0]  alu_res;
  flags_t         relation;

  assign ir_op   = ir_q[DW-1:OPLSB];
  assign ir_addr = ir_q[AW-1:0];

  acc_decode u_dec (
    .opcode (ir_op),
    .kind   (kind),
    .sel    (sel)
  );

  acc_branch u_br (
    .opcode (ir_op),
    .flags  (flag_q),
    .take   (take)
  );

  acc_alu #(.DW(DW)) u_alu (
    .acc      (acc_q),
    .operand  (mdr_q),
    .left     (left_q),
    .sel      (sel),
    .result   (alu_res),
    .relation (relation)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_F0;
      pc_q     <= '0;
      mar_q    <= '0;
      mdr_q    <= '0;
      ir_q     <= '0;
      acc_q    <= '0;
      left_q   <= '0;
      yaddr_q  <= '0;
      second_q <= 1'b0;
      flag_q   <= '0;
    end else begin
      case (state_q)
        S_F0: begin
          mar_q   <= pc_q;
          state_q <= S_F1;
        end
        S_F1: state_q <= S_F2;
        S_F2: begin
          mdr_q   <= mem_rdata;
          state_q <= S_F3;
        end
        S_F3: begin
          ir_q    <= mdr_q;
          pc_q    <= pc_q + AW'(1);
          state_q <= S_DEC;
        end
        S_DEC: begin
          case (kind)
            K_JUMP: begin
              if (take) pc_q <= ir_addr;
              state_q <= S_F0;
            end
            K_STORE: begin
              mar_q   <= ir_addr;
              mdr_q   <= acc_q;
              state_q <= S_WR;
            end
            K_LOAD, K_ADD: begin
              mar_q    <= ir_addr;
              second_q <= 1'b0;
              state_q  <= S_R1;
            end
            K_MOVE, K_CMP: begin
              mar_q   <= pc_q;
              state_q <= S_X1;
            end
            default: state_q <= S_HALT;
          endcase
        end
        S_X1: state_q <= S_X2;
        S_X2: begin
          mdr_q   <= mem_rdata;
          state_q <= S_X3;
        end
        S_X3: begin
          yaddr_q  <= mdr_q[AW-1:0];
          pc_q     <= pc_q + AW'(1);
          mar_q    <= ir_addr;
          second_q <= 1'b0;
          state_q  <= S_R1;
        end
        S_R1: state_q <= S_R2;
        S_R2: begin
          mdr_q   <= mem_rdata;
          state_q <= S_EX;
        end
        S_EX: begin
          case (kind)
            K_LOAD, K_ADD: begin
              acc_q   <= alu_res;
              state_q <= S_F0;
            end
            K_MOVE: begin
              mar_q   <= yaddr_q;
              state_q <= S_WR;
            end
            K_CMP: begin
              if (!second_q) begin
                left_q   <= mdr_q;
                mar_q    <= yaddr_q;
                second_q <= 1'b1;
                state_q  <= S_R1;
              end else begin
                flag_q  <= relation;
                state_q <= S_F0;
              end
            end
            default: state_q <= S_HALT;
          endcase
        end
        S_WR:    state_q <= S_F0;
        S_HALT:  state_q <= S_HALT;
        default: state_q <= S_HALT;
      endcase
    end
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = mdr_q;
  assign mem_we    = (state_q == S_WR);
  assign halted    = (state_q == S_HALT);
  assign pc        = pc_q;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
  import acc_cpu_pkg::*;
#(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_we,
  input logic          halted,
  input logic [AW-1:0] pc,
  input flags_t        flags,
  input state_e        state
);

  // R6
  flags_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flags));

  // R6
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_EX) |=> $stable(flags));

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(pc)));

  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we);

  // R3
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

endmodule

bind acc_cpu acc_cpu_chk #(.AW(AW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .mem_we (mem_we),
  .halted (halted),
  .pc     (pc),
  .flags  (flag_q),
  .state  (state_q)
);

// File: tb/acc_cpu_test.sv
module acc_cpu_test;

  localparam int AW = 12;
  localparam int DW = 16;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_we;
  logic [DW-1:0] mem_rdata;
  logic          halted;
  logic [AW-1:0] pc;

  always #4 clk = ~clk;   // 125 MHz

  acc_cpu #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted), .pc(pc)
  );

  // memory behind the core, plus a load port for the bench
  logic [DW-1:0] ram [NW];
  logic          ld_en = 1'b0;
  logic [AW-1:0] ld_a = '0;
  logic [DW-1:0] ld_d = '0;

  always @(posedge clk) begin
    if (ld_en)       ram[ld_a] <= ld_d;
    else if (mem_we) ram[mem_addr] <= mem_wdata;
    mem_rdata <= ram[mem_addr];
  end

  // reference model state
  logic [DW-1:0] ref_mem [NW];
  int            n_chk = 0;
  int            n_err = 0;
  int            k, m_len, m_wcyc, post;
  logic [AW-1:0] m_p, m_next, m_waddr, m_stop;
  logic [DW-1:0] m_r, m_wdata;
  logic          m_lt, m_eq, m_gt;
  logic          m_two, m_wr, m_stopper, m_halted;
  string         m_tag;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic poke(input int a, input int d);
    ld_en = 1'b1;
    ld_a  = AW'(a);
    ld_d  = DW'(d);
    ref_mem[a] = DW'(d);
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // execute one instruction whole and record its cycle timetable
  task automatic start_instr();
    logic [DW-1:0] w, x, y;
    logic [3:0]    op;
    logic [AW-1:0] a, b;
    logic          t;
    w = ref_mem[m_p];
    op = w[15:12];
    a = w[AW-1:0];
    b = ref_mem[m_p + AW'(1)][AW-1:0];
    m_two = 1'b0; m_wr = 1'b0; m_stopper = 1'b0;
    m_next = m_p + AW'(1);
    m_wcyc = -1; m_waddr = '0; m_wdata = '0;
    case (op)
      4'd0: begin m_tag = "R3"; m_len = 8; m_r = ref_mem[a]; end
      4'd1: begin
        m_tag = "R3"; m_len = 6; m_wr = 1'b1; m_wcyc = 5;
        m_waddr = a; m_wdata = m_r; ref_mem[a] = m_r;
      end
      4'd2: begin
        m_tag = "R5"; m_len = 12; m_two = 1'b1; m_wr = 1'b1; m_wcyc = 11;
        m_waddr = b; m_wdata = ref_mem[a]; ref_mem[b] = ref_mem[a];
        m_next = m_p + AW'(2);
      end
      4'd3: begin m_tag = "R4"; m_len = 8; m_r = m_r + ref_mem[a]; end
      4'd4: begin
        m_tag = "R6"; m_len = 14; m_two = 1'b1; m_next = m_p + AW'(2);
        x = ref_mem[a]; y = ref_mem[b];
        m_gt = (x > y); m_eq = (x == y); m_lt = (x < y);
      end
      4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd10, 4'd11: begin
        m_tag = (op == 4'd5) ? "R7" : "R8";
        m_len = 5;
        case (op)
          4'd5:    t = 1'b1;
          4'd6:    t = m_gt;
          4'd7:    t = m_gt | m_eq;
          4'd8:    t = m_lt;
          4'd9:    t = m_lt | m_eq;
          4'd10:   t = m_eq;
          default: t = ~m_eq;
        endcase
        if (t) m_next = a;
      end
      4'd15:   begin m_tag = "R9";  m_len = 5; m_stopper = 1'b1; end
      default: begin m_tag = "R10"; m_len = 5; m_stopper = 1'b1; end
    endcase
  endtask

  task automatic run_prog(input int limit);
    logic [AW-1:0] ep;
    m_p = '0; k = 0; m_r = '0; m_lt = 0; m_eq = 0; m_gt = 0;
    m_halted = 1'b0; post = 0; m_stop = '0; m_tag = "R1";
    // reset state while held (R1)
    chk("R1", "pc in reset", int'(pc), 0);
    chk("R1", "halted in reset", int'(halted), 0);
    chk("R1", "mem_we in reset", int'(mem_we), 0);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < limit; cyc++) begin
      if (m_halted) begin
        chk(m_tag, "halted after stop", int'(halted), 1);
        chk(m_tag, "pc frozen", int'(pc), int'(m_stop));
        chk(m_tag, "no write after stop", int'(mem_we), 0);
        post++;
        if (post == 20) break;
      end else begin
        if (k == 0) start_instr();
        if (k < 4)                  ep = m_p;
        else if (k < 8 || !m_two)   ep = m_p + AW'(1);
        else                        ep = m_p + AW'(2);
        chk((k < 5) ? "R2" : m_tag, "pc", int'(pc), int'(ep));
        chk(m_tag, "halted", int'(halted), 0);
        chk(m_tag, "mem_we", int'(mem_we), (m_wr && k == m_wcyc) ? 1 : 0);
        if (m_wr && k == m_wcyc) begin
          chk(m_tag, "write address", int'(mem_addr), int'(m_waddr));
          chk(m_tag, "write data", int'(mem_wdata), int'(m_wdata));
        end
        k++;
        if (k == m_len) begin
          k = 0;
          if (m_stopper) begin
            m_halted = 1'b1;
            m_stop = m_p + AW'(1);
          end else begin
            m_p = m_next;
          end
        end
      end
      @(negedge clk);
    end
    if (post < 20) begin
      n_chk++; n_err++;
      $display("FAIL R9 watchdog: halted=%0d expected 1", halted);
    end
    rst_n = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    for (int i = 0; i < NW; i++) poke(i, 0);

    // program 1: transfers, arithmetic, compares and every jump
    poke(12'h000, 16'h70F0);  // JGE, not taken after reset (R1)
    poke(12'h001, 16'hB003);  // JNE, taken after reset (R1)
    poke(12'h002, 16'hF000);
    poke(12'h003, 16'h0100);  // LOAD
    poke(12'h004, 16'h3101);  // ADD with wrap (R4)
    poke(12'h005, 16'h1102);  // STORE (R3)
    poke(12'h006, 16'h2100);  // MOVE 100 -> 103 (R5)
    poke(12'h007, 16'h0103);
    poke(12'h008, 16'h4100);  // COMPARE less (R6)
    poke(12'h009, 16'h0101);
    poke(12'h00A, 16'h60F0);
    poke(12'h00B, 16'h70F0);
    poke(12'h00C, 16'hA0F0);
    poke(12'h00D, 16'h900F);
    poke(12'h00E, 16'hF000);
    poke(12'h00F, 16'h8011);
    poke(12'h010, 16'hF000);
    poke(12'h011, 16'h4101);  // COMPARE greater
    poke(12'h012, 16'h0100);
    poke(12'h013, 16'h90F0);
    poke(12'h014, 16'h80F0);
    poke(12'h015, 16'h6017);
    poke(12'h016, 16'hF000);
    poke(12'h017, 16'h4102);  // COMPARE equal
    poke(12'h018, 16'h0102);
    poke(12'h019, 16'hB0F0);
    poke(12'h01A, 16'hA01C);
    poke(12'h01B, 16'hF000);
    poke(12'h01C, 16'h0103);  // LOAD, flags must persist
    poke(12'h01D, 16'h701F);
    poke(12'h01E, 16'hF000);
    poke(12'h01F, 16'h3102);
    poke(12'h020, 16'h1104);
    poke(12'h021, 16'h5030);  // JUMP (R7)
    poke(12'h030, 16'hF000);  // HALT (R9)
    poke(12'h100, 16'h1234);
    poke(12'h101, 16'hF000);
    run_prog(2000);

    // program 2: undefined opcode stops the core (R10)
    poke(12'h000, 16'h0100);
    poke(12'h001, 16'hD000);
    poke(12'h002, 16'h1105);
    run_prog(400);

    // program 3: another undefined code after a store (R10)
    poke(12'h000, 16'h3101);
    poke(12'h001, 16'h1106);
    poke(12'h002, 16'hC000);
    poke(12'h003, 16'h1107);
    run_prog(400);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++; n_err++;
    $display("FAIL R9 watchdog: run did not finish, actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule